// File: doc/BRIEF.md
# Line-Port Relay Control and Status Reporter

This block looks after the general-purpose pins of four line ports. Every port has a bank of four relay-driver outputs and a pair of status inputs. A host reaches the block over a byte-wide message path. Commands come in as single-cycle strobes. Reports go out one byte at a time, and the host acknowledges each byte.

A set command writes all four relay outputs of one port together. Those outputs keep their value through a soft reset, and only a hardware reset clears them. Status inputs pass through a two-stage synchroniser. Each port's synchronised level is compared with the level last reported for it. A difference, or a status-request command from the host, makes the port pending. A round-robin arbiter picks one pending port at a time, and a small state machine sends its two-byte report.

The state machine has three states. IDLE moves to HDR when the arbiter grants a port. At that moment the machine captures the port index and the port's current status level. HDR moves to STAT when the host acknowledges the header byte. STAT moves back to IDLE when the status byte is acknowledged. On that return the captured level becomes the port's reported level and the round-robin pointer moves past the port. A soft-reset command sends any state straight to IDLE.

Top module: `lp_gpio_reporter`

## Requirements
- R1: After hardware reset (rst_n low), every relay output is 0 and tx_valid is 0. With all status inputs at 0, no message is sent afterwards.
- R2: A command with cmd_op = 1 (set) loads cmd_data[3:0] into relays[4*cmd_port +: 4] on the next clock. The relays of the other ports keep their values.
- R3: Relay outputs keep their value until a later set command to the same port. Status-request commands and message traffic have no effect on them.
- R4: A command with cmd_op = 3 (soft reset) leaves all relay outputs unchanged and ends any message in progress, so tx_valid drops on the next clock. It discards outstanding status requests and takes the current synchronised status levels as already reported. Later status changes are reported normally.
- R5: A synchronised change on a port's status inputs sends a two-byte message. Byte 1 has bits [7:4] = 4'b1010, bits [3:2] = 0 and bits [1:0] = port index. Byte 2 has bits [7:2] = 0, bit 0 = stat_in[2*port] and bit 1 = stat_in[2*port+1].
- R6: Each byte stays on tx_byte with tx_valid high, unchanged, until a one-cycle tx_ack. After the second acknowledge, tx_valid is low for at least one cycle.
- R7: Byte 2 carries the level captured when the header is first presented. Changes on the same port while its message is in flight start nothing until the message is acknowledged. After that, one further message carries the latest level, provided that level differs from the one sent. Changes on a port that is waiting are merged, and only its latest level is sent.
- R8: A command with cmd_op = 2 (status request) for a port sends that port's message even when its status has not changed.
- R9: Pending ports are served one at a time in round-robin order. The search starts at the port after the one most recently completed.
- R10: A waiting port whose status returns to its last reported level before it is served sends no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 none, 1 set relays, 2 status request, 3 soft reset |
| cmd_port | input | 2 | Addressed line port |
| cmd_data | input | 4 | Relay value for a set command |
| stat_in | input | 8 | Status pins, two per port, port p at bits [2p+1:2p] |
| relays | output | 16 | Relay outputs, port p at bits [4p+3:4p] |
| tx_valid | output | 1 | Outbound byte present |
| tx_byte | output | 8 | Outbound byte |
| tx_ack | input | 1 | Host acknowledge of the presented byte |

## Verification
The hardest case to reach is the interaction between the one message in flight and the state of the waiting ports. This covers merged changes, changes that revert, and the rotating grant order, and none of it can be seen unless the host holds back its acknowledges. The stimulus first starts a message and leaves it unacknowledged. While that message is stalled, it toggles status pins on other ports, or on the same port, and queues status requests for several ports. Only then does it release the acknowledges. The order and content of the messages that follow are then compared with an arithmetic model of the pending set and the round-robin pointer.

// File: rtl/lp_gpio_pkg.sv
package lp_gpio_pkg;
    typedef enum logic [1:0] {
        OP_NOP     = 2'd0,
        OP_SET     = 2'd1,
        OP_STATREQ = 2'd2,
        OP_SWRST   = 2'd3
    } cmd_op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_STAT = 2'd2
    } tx_state_t;

    localparam logic [3:0] REPORT_OPCODE = 4'b1010;
endpackage

// File: rtl/lp_gpio_sync.sv
module lp_gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lp_gpio_relay_bank.sv
module lp_gpio_relay_bank #(
    parameter int NPORTS = 4,
    parameter int NRELAY = 4,
    localparam int PW    = $clog2(NPORTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [PW-1:0]            set_port,
    input  logic [NRELAY-1:0]        set_val,
    output logic [NPORTS*NRELAY-1:0] relays
);
    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            logic [NRELAY-1:0] bank_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                bank_q <= '0;
                else if (set_en && set_port == PW'(p))     bank_q <= set_val;
            end

            assign relays[p*NRELAY +: NRELAY] = bank_q;

            // R2
            relay_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (set_en && set_port == PW'(p)) |=> (relays[p*NRELAY +: NRELAY] == $past(set_val)));
        end
    endgenerate

    // R3
    relay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en |=> $stable(relays));
endmodule

// File: rtl/lp_gpio_rr_arb.sv
module lp_gpio_rr_arb #(
    parameter int N   = 4,
    localparam int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic          gnt_valid,
    output logic [PW-1:0] gnt_idx
);
    always_comb begin
        int t;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = N-1; i >= 0; i--) begin
            t = int'(ptr) + i;
            if (t >= N) t = t - N;
            if (req[t]) begin
                gnt_valid = 1'b1;
                gnt_idx   = PW'(t);
            end
        end
    end
endmodule

// File: rtl/lp_gpio_reporter.sv
module lp_gpio_reporter
    import lp_gpio_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int NRELAY = 4,
    parameter int NSTAT  = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PW    = $clog2(NPORTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [PW-1:0]            cmd_port,
    input  logic [NRELAY-1:0]        cmd_data,
    input  logic [NPORTS*NSTAT-1:0]  stat_in,
    output logic [NPORTS*NRELAY-1:0] relays,
    output logic                     tx_valid,
    output logic [7:0]               tx_byte,
    input  logic                     tx_ack
);
    localparam logic [PW-1:0] LAST_PORT = PW'(NPORTS-1);

    cmd_op_t   op;
    logic      set_en, streq_en, swrst_en;
    tx_state_t state, state_n;

    logic [NPORTS*NSTAT-1:0] sync_st;
    logic [NPORTS*NSTAT-1:0] reported;
    logic [NPORTS-1:0]       req_flag;
    logic [NPORTS-1:0]       pend;
    logic [PW-1:0]           rr_ptr;
    logic [PW-1:0]           cur;
    logic [NSTAT-1:0]        snap;
    logic                    gnt_valid;
    logic [PW-1:0]           gnt_idx;
    logic                    take, finish;

    assign op       = cmd_op_t'(cmd_op);
    assign set_en   = cmd_valid && (op == OP_SET);
    assign streq_en = cmd_valid && (op == OP_STATREQ);
    assign swrst_en = cmd_valid && (op == OP_SWRST);

    lp_gpio_sync #(.W(NPORTS*NSTAT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(stat_in), .q(sync_st)
    );

    lp_gpio_relay_bank #(.NPORTS(NPORTS), .NRELAY(NRELAY)) u_relays (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_port(cmd_port),
        .set_val(cmd_data), .relays(relays)
    );

    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            pend[p] = ((sync_st[p*NSTAT +: NSTAT] != reported[p*NSTAT +: NSTAT]) || req_flag[p])
                      && !((state != ST_IDLE) && (cur == PW'(p)));
        end
    end

    lp_gpio_rr_arb #(.N(NPORTS)) u_arb (
        .req(pend), .ptr(rr_ptr), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    assign take   = (state == ST_IDLE) && gnt_valid && !swrst_en;
    assign finish = (state == ST_STAT) && tx_ack && !swrst_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        if (swrst_en) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (gnt_valid) state_n = ST_HDR;
                ST_HDR:  if (tx_ack)    state_n = ST_STAT;
                ST_STAT: if (tx_ack)    state_n = ST_IDLE;
                default:                state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_byte  = 8'h00;
        unique case (state)
            ST_IDLE: ;
            ST_HDR: begin
                tx_valid = 1'b1;
                tx_byte  = {REPORT_OPCODE, {(4-PW){1'b0}}, cur};
            end
            ST_STAT: begin
                tx_valid = 1'b1;
                tx_byte  = {{(8-NSTAT){1'b0}}, snap};
            end
            default: ;
        endcase
    end

    // report bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur      <= '0;
            snap     <= '0;
            reported <= '0;
            req_flag <= '0;
            rr_ptr   <= '0;
        end else if (swrst_en) begin
            req_flag <= '0;
            reported <= sync_st;
        end else begin
            if (take) begin
                cur  <= gnt_idx;
                snap <= sync_st[gnt_idx*NSTAT +: NSTAT];
            end
            if (finish) begin
                reported[cur*NSTAT +: NSTAT] <= snap;
                req_flag[cur] <= 1'b0;
                rr_ptr <= (cur == LAST_PORT) ? '0 : cur + 1'b1;
            end
            if (streq_en) req_flag[cmd_port] <= 1'b1;
        end
    end

    // R6
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ack && !swrst_en) |=> (tx_valid && $stable(tx_byte)));

    // R6
    gap_after_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !tx_valid);

    // R9
    rr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && pend[rr_ptr]) |-> (gnt_valid && gnt_idx == rr_ptr));

    // R4
    swrst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_en |=> !tx_valid);
endmodule

// File: tb/lp_gpio_reporter_bench.sv
module lp_gpio_reporter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [1:0]  cmd_port;
    logic [3:0]  cmd_data;
    logic [7:0]  stat_in;
    logic [15:0] relays;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ack;

    int errors = 0;
    int checks = 0;
    logic [3:0] exp_rel [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_gpio_reporter u_lp_gpio_reporter (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_port(cmd_port), .cmd_data(cmd_data), .stat_in(stat_in),
        .relays(relays), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ack(tx_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rel_model();
        return {exp_rel[3], exp_rel[2], exp_rel[1], exp_rel[0]};
    endfunction

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [1:0] port, input logic [3:0] data);
        cmd_valid = 1'b1; cmd_op = op; cmd_port = port; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic set_stat(input int p, input logic [1:0] v);
        stat_in[p*2 +: 2] = v;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 60 && !tx_valid; i++) @(negedge clk);
    endtask

    task automatic pulse_ack();
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
    endtask

    task automatic take_msg(input string tag, input int p, input logic [1:0] st);
        wait_valid();
        chk({tag, " header"}, {23'd0, tx_valid, tx_byte}, {23'd1, 4'b1010, 2'b00, 2'(p)});
        pulse_ack();
        chk({tag, " status"}, {23'd0, tx_valid, tx_byte}, {23'd1, 6'd0, st});
        pulse_ack();
    endtask

    task automatic expect_quiet(input string tag, input int n);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_valid) seen = 1'b1;
        end
        chk({tag, " quiet"}, {31'd0, seen}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] held;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_port = 2'd0;
        cmd_data = 4'd0; stat_in = 8'd0; tx_ack = 1'b0;
        for (int p = 0; p < 4; p++) exp_rel[p] = 4'd0;
        wait_cycles(3);
        // R1 reset state
        chk("R1 relays", {16'd0, relays}, 32'd0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        rst_n = 1'b1;
        expect_quiet("R1", 12);

        // R2 sweep of every port and value
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 16; v++) begin
                send_cmd(2'd1, 2'(p), 4'(v));
                exp_rel[p] = 4'(v);
                chk("R2 set", {16'd0, relays}, {16'd0, rel_model()});
            end
        end
        for (int p = 0; p < 4; p++) begin
            send_cmd(2'd1, 2'(p), 4'(3*p + 5));
            exp_rel[p] = 4'(3*p + 5);
        end
        chk("R2 distinct", {16'd0, relays}, {16'd0, rel_model()});

        // R5 automatic reports over all ports and levels
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [1:0] v;
                v = 2'((k + 1) % 4);
                set_stat(p, v);
                take_msg("R5", p, v);
            end
        end
        expect_quiet("R5", 10);

        // R8 status request without change
        for (int p = 0; p < 4; p++) begin
            set_stat(p, 2'(p));
        end
        for (int p = 0; p < 4; p++) begin
            if (p != 0) take_msg("R8 setup", p, 2'(p));
        end
        for (int p = 3; p >= 0; p--) begin
            send_cmd(2'd2, 2'(p), 4'd0);
            take_msg("R8", p, 2'(p));
        end
        expect_quiet("R8", 10);
        // R3 relays untouched by traffic
        chk("R3 relays after traffic", {16'd0, relays}, {16'd0, rel_model()});

        // R6 hold without ack
        set_stat(3, 2'd1);
        wait_valid();
        held = tx_byte;
        wait_cycles(7);
        chk("R6 hold", {23'd0, tx_valid, tx_byte}, {23'd1, held});
        take_msg("R6", 3, 2'd1);
        expect_quiet("R6", 6);

        // R7 same-port changes during flight
        set_stat(0, 2'd1);
        wait_valid();
        set_stat(0, 2'd2); wait_cycles(4);
        set_stat(0, 2'd3); wait_cycles(4);
        take_msg("R7 first", 0, 2'd1);
        take_msg("R7 latest", 0, 2'd3);
        expect_quiet("R7", 10);

        // R7 merged changes on a waiting port
        send_cmd(2'd2, 2'd1, 4'd0);
        wait_valid();
        set_stat(2, 2'd0); wait_cycles(3);
        set_stat(2, 2'd1); wait_cycles(3);
        set_stat(2, 2'd3); wait_cycles(4);
        take_msg("R7 busy", 1, 2'd1);
        take_msg("R7 merged", 2, 2'd3);
        expect_quiet("R7 merged", 10);

        // R10 change that reverts before service
        send_cmd(2'd2, 2'd1, 4'd0);
        wait_valid();
        set_stat(2, 2'd0); wait_cycles(4);
        set_stat(2, 2'd3); wait_cycles(4);
        take_msg("R10 busy", 1, 2'd1);
        expect_quiet("R10", 12);

        // R9 round robin; levels: p0=3 p1=1 p2=3 p3=1; pointer now 2
        send_cmd(2'd2, 2'd0, 4'd0);
        wait_valid();
        send_cmd(2'd2, 2'd3, 4'd0);
        send_cmd(2'd2, 2'd1, 4'd0);
        send_cmd(2'd2, 2'd2, 4'd0);
        take_msg("R9 a0", 0, 2'd3);
        take_msg("R9 a1", 1, 2'd1);
        take_msg("R9 a2", 2, 2'd3);
        take_msg("R9 a3", 3, 2'd1);
        send_cmd(2'd2, 2'd2, 4'd0);
        wait_valid();
        send_cmd(2'd2, 2'd0, 4'd0);
        send_cmd(2'd2, 2'd3, 4'd0);
        take_msg("R9 b2", 2, 2'd3);
        take_msg("R9 b3", 3, 2'd1);
        take_msg("R9 b0", 0, 2'd3);
        expect_quiet("R9", 10);

        // R4 soft reset mid-message
        send_cmd(2'd2, 2'd1, 4'd0);
        wait_valid();
        send_cmd(2'd2, 2'd3, 4'd0);
        set_stat(0, 2'd0);
        wait_cycles(4);
        send_cmd(2'd3, 2'd0, 4'd0);
        chk("R4 tx dropped", {31'd0, tx_valid}, 32'd0);
        chk("R4 relays kept", {16'd0, relays}, {16'd0, rel_model()});
        expect_quiet("R4", 20);
        set_stat(0, 2'd2);
        take_msg("R4 after", 0, 2'd2);
        expect_quiet("R4 after", 8);
        chk("R3 relays final", {16'd0, relays}, {16'd0, rel_model()});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule